// File: doc/BRIEF.md
# Successive-Approximation ADC Port Controller

This block is the digital half of a successive-approximation converter. It sits on a small 8-bit bus port that uses cyc/stb/we/ack signalling. A processor writes a control word. The word picks one of four reference voltages and can launch a conversion. The block then runs a bit-serial binary search. It drives a trial code to an external DAC and reads back one comparator bit on every clock. The comparator bit is 1 when the analog input lies above the trial code.

Each search starts from a code that is all ones except the top bit. At every step the current bit takes the comparator's answer. The next bit down is then cleared, and the bits below it stay at one. After the last bit is decided, the result is latched and a done flag is raised. The hold output asks the external sample/hold to freeze the input while the search runs. Software polls the status word for done and then reads the result.

Top module: `sar_adc_port`

## Requirements
- R1: After reset, done is 0, hold_o is 0, ref_o is 4'b0001, dac_o is 0, and reads at both addresses return 0.
- R2: ack_o is 1 in exactly the cycles where cyc_i and stb_i are both 1, for reads and writes at either address.
- R3: A write at address 0 loads dat_i[1:0] as the reference index n. From the next cycle, ref_o has bit n set and every other bit clear. ref_o always has exactly one bit set.
- R4: A write at address 0 with dat_i[2]=1 starts a conversion. In the cycle after the write edge, dac_o is 8'h7F, hold_o is 1 and done is 0.
- R5: While a conversion runs, bit k is the bit under test. Every trial code on dac_o keeps the bits above k as already decided, has 0 at bit k and has 1 in all bits below k. Bit k is decided as the value of cmp_i sampled at the next clock, starting from bit 7.
- R6: Done rises exactly 8 clock edges after the edge that accepts the start. hold_o falls on that same edge, and hold_o and done are never 1 together.
- R7: With an ideal comparator (cmp_i = 1 when the input value is greater than dac_o), the result read at address 0 equals the input value, for every input from 0 to 255 and every reference index.
- R8: A read at address 1 returns done in bit 0 and 0 in bits 7:1.
- R9: A write at address 1, or any write attempt with cyc_i or stb_i low, has no effect. ref_o does not change, no conversion starts, and done and the result are kept.
- R10: A start written while a conversion is running restarts the search from 8'h7F. Done then follows 8 edges after the new start, and the result reflects the new input.
- R11: A write at address 0 with dat_i[2]=0 changes only the reference. No conversion starts, and done and the result are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | 1 | Register address: 0 = control/result, 1 = status |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data, combinational |
| ack_o | output | 1 | Acknowledge |
| cmp_i | input | 1 | Comparator answer: analog input is above dac_o |
| dac_o | output | 8 | Trial code for the external DAC |
| hold_o | output | 1 | Sample/hold freeze, high during a conversion |
| ref_o | output | 4 | One-hot reference voltage select |

## Verification
Some properties are checked on every cycle:
- the one-hot reference lines;
- the trial-code shape, with a zero at the bit under test and ones below it;
- the capture of cmp_i into the bit under test;
- the exact 8-edge distance from start to done, measured with a counter;
- the exclusion of hold and done;
- the start code;
- the immunity of the reference lines to writes at address 1.

Other behaviour can only be shown by the bench's scenarios:
- that the full search lands on the input value, swept over all 256 inputs and cycling through the references;
- that ignored writes leave done and the result untouched;
- that a restart in mid-search yields the new input's value.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // register map of the bus port
  typedef enum logic {
    REG_CTRL_DATA = 1'b0,
    REG_STATUS    = 1'b1
  } reg_addr_e;

  // control word fields
  localparam int CTRL_GO_BIT   = 2;
  localparam int CTRL_REF_LSB  = 0;
  // status word fields
  localparam int STAT_DONE_BIT = 0;
endpackage

// File: rtl/sar_step.sv
module sar_step #(
  parameter int DW = 8,
  localparam int IW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          cmp,
  output logic [DW-1:0] code,
  output logic [DW-1:0] result,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done
);
  // first trial: top bit cleared, every other bit set
  function automatic logic [DW-1:0] first_trial();
    logic [DW-1:0] t;
    t = '1;
    t[DW-1] = 1'b0;
    return t;
  endfunction

  // settle bit i with the comparator answer, open the next bit down
  function automatic logic [DW-1:0] advance(input logic [DW-1:0] c,
                                            input logic [IW-1:0] i,
                                            input logic b);
    logic [DW-1:0] t;
    t = c;
    t[i] = b;
    if (i != '0) t[i - 1'b1] = 1'b0;
    return t;
  endfunction

  logic [DW-1:0] next_code;
  logic          last_step;

  assign next_code = advance(code, idx, cmp);
  assign last_step = busy && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= '0;
      result <= '0;
      idx    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (go) begin
      code <= first_trial();
      idx  <= IW'(DW - 1);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      code <= next_code;
      if (last_step) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= next_code;
      end else begin
        idx <= idx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ref_decode.sv
module ref_decode #(
  parameter int NREF = 4,
  localparam int RW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic [RW-1:0]   sel,
  output logic [NREF-1:0] lines
);
  for (genvar g = 0; g < NREF; g++) begin : g_line
    assign lines[g] = (sel == RW'(g));
  end
endmodule

// File: rtl/port_regs.sv
module port_regs
  import sar_pkg::*;
#(
  parameter int DW = 8,
  parameter int NREF = 4,
  localparam int RW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic          adr,
  input  logic [DW-1:0] wdata,
  input  logic          done,
  input  logic [DW-1:0] result,
  output logic [DW-1:0] rdata,
  output logic          ack,
  output logic          go,
  output logic [RW-1:0] ref_sel
);
  logic          access;
  logic          wr_ctrl;
  logic [DW-1:0] status_word;

  assign access  = cyc && stb;
  assign ack     = access;
  assign wr_ctrl = access && we && (reg_addr_e'(adr) == REG_CTRL_DATA);
  assign go      = wr_ctrl && wdata[CTRL_GO_BIT];

  always_comb begin
    status_word = '0;
    status_word[STAT_DONE_BIT] = done;
  end

  assign rdata = (reg_addr_e'(adr) == REG_STATUS) ? status_word : result;

  always_ff @(posedge clk) begin
    if (rst) ref_sel <= '0;
    else if (wr_ctrl) ref_sel <= wdata[CTRL_REF_LSB +: RW];
  end
endmodule

// File: rtl/sar_adc_port.sv
module sar_adc_port #(
  parameter int DW = 8,
  parameter int NREF = 4,
  localparam int RW = (NREF > 1) ? $clog2(NREF) : 1,
  localparam int IW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            cyc_i,
  input  logic            stb_i,
  input  logic            we_i,
  input  logic            adr_i,
  input  logic [DW-1:0]   dat_i,
  output logic [DW-1:0]   dat_o,
  output logic            ack_o,
  input  logic            cmp_i,
  output logic [DW-1:0]   dac_o,
  output logic            hold_o,
  output logic [NREF-1:0] ref_o
);
  // internal events brought out by name for the checker
  logic          start_w;
  logic          busy_w;
  logic          done_w;
  logic [IW-1:0] bit_idx;
  logic [DW-1:0] result_w;
  logic [RW-1:0] ref_sel_w;

  port_regs #(.DW(DW), .NREF(NREF)) u_regs (
    .clk(clk_i), .rst(rst_i), .cyc(cyc_i), .stb(stb_i), .we(we_i),
    .adr(adr_i), .wdata(dat_i), .done(done_w), .result(result_w),
    .rdata(dat_o), .ack(ack_o), .go(start_w), .ref_sel(ref_sel_w)
  );

  sar_step #(.DW(DW)) u_step (
    .clk(clk_i), .rst(rst_i), .go(start_w), .cmp(cmp_i),
    .code(dac_o), .result(result_w), .idx(bit_idx),
    .busy(busy_w), .done(done_w)
  );

  ref_decode #(.NREF(NREF)) u_ref (
    .sel(ref_sel_w), .lines(ref_o)
  );

  assign hold_o = busy_w;
endmodule

// File: rtl/sar_adc_port_chk.sv
module sar_adc_port_chk #(
  parameter int DW = 8,
  parameter int NREF = 4,
  localparam int IW = (DW > 1) ? $clog2(DW) : 1,
  localparam int CW = $clog2(DW + 1) + 1
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic            cyc_i,
  input logic            stb_i,
  input logic            we_i,
  input logic            adr_i,
  input logic [DW-1:0]   dat_i,
  input logic            cmp_i,
  input logic [DW-1:0]   dac_o,
  input logic            hold_o,
  input logic [NREF-1:0] ref_o,
  input logic            done_w,
  input logic [IW-1:0]   bit_idx
);
  logic          start_evt;
  logic          addr1_wr;
  logic [DW-1:0] low_ones;
  logic [CW-1:0] since_go;

  assign start_evt = cyc_i && stb_i && we_i && !adr_i && dat_i[2];
  assign addr1_wr  = cyc_i && stb_i && we_i && adr_i;
  assign low_ones  = (DW'(1) << bit_idx) - DW'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i || start_evt) since_go <= '0;
    else if (hold_o) since_go <= since_go + 1'b1;
  end

  a_r3_ref_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(ref_o) == 1);

  a_r4_start_code: assert property (@(posedge clk_i) disable iff (rst_i)
    start_evt |=> (dac_o == {1'b0, {(DW-1){1'b1}}}) && hold_o && !done_w);

  a_r5_trial_shape: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_o |-> (dac_o[bit_idx] == 1'b0) && ((dac_o & low_ones) == low_ones));

  a_r5_bit_capture: assert property (@(posedge clk_i) disable iff (rst_i)
    (hold_o && !start_evt && bit_idx != '0) |=> dac_o[$past(bit_idx)] == $past(cmp_i));

  a_r6_done_latency: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(done_w) |-> since_go == CW'(DW));

  a_r6_hold_done_excl: assert property (@(posedge clk_i) disable iff (rst_i)
    !(hold_o && done_w));

  a_r9_addr1_ref: assert property (@(posedge clk_i) disable iff (rst_i)
    addr1_wr |=> $stable(ref_o));

  a_r9_addr1_nostart: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr1_wr && !hold_o) |=> !hold_o);
endmodule

bind sar_adc_port sar_adc_port_chk #(.DW(DW), .NREF(NREF)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
  .adr_i(adr_i), .dat_i(dat_i), .cmp_i(cmp_i), .dac_o(dac_o),
  .hold_o(hold_o), .ref_o(ref_o), .done_w(done_w), .bit_idx(bit_idx)
);

// File: tb/sim_sar_adc_port.sv
`timescale 1ns/1ps
module sim_sar_adc_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc = 1'b0, stb = 1'b0, we = 1'b0, adr = 1'b0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic       ack;
  logic       cmp;
  logic [7:0] dac;
  logic       hold;
  logic [3:0] refl;
  int         vin = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         ended = 1'b0;

  always #4 clk = ~clk;

  assign cmp = (vin > int'(dac));

  sar_adc_port u0 (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack), .cmp_i(cmp),
    .dac_o(dac), .hold_o(hold), .ref_o(refl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // combinational read, consumes no clock edge
  task automatic rd(input logic a, output logic [7:0] v);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a;
    #2;
    v = rdat;
    chk(ack == 1'b1, "R2 read ack", ack, 1);
    cyc = 1'b0; stb = 1'b0;
  endtask

  // drive one bus write cycle from a negedge, return at the next negedge
  task automatic drive(input logic c, input logic s, input logic a, input logic [7:0] d);
    cyc = c; stb = s; we = 1'b1; adr = a; wdat = d;
    #2;
    chk(ack == (c && s), "R2 write ack", ack, int'(c && s));
    @(posedge clk);
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  function automatic int exp_trial(input int v, input int j);
    int k;
    k = 7 - j;
    return ((v >> (k + 1)) << (k + 1)) | ((1 << k) - 1);
  endfunction

  task automatic convert(input int v, input int sel, input bit trials);
    logic [7:0] r;
    vin = v;
    drive(1'b1, 1'b1, 1'b0, 8'(4 + sel));
    chk(dac == 8'h7F, "R4 first trial", dac, 8'h7F);
    rd(1'b1, r);
    chk(r == 8'h00, "R4 done cleared", r, 0);
    for (int j = 0; j < 8; j++) begin
      chk(hold == 1'b1, "R6 hold during search", hold, 1);
      if (trials) chk(int'(dac) == exp_trial(v, j), "R5 trial code", dac, exp_trial(v, j));
      @(negedge clk);
    end
    chk(hold == 1'b0, "R6 hold released", hold, 0);
    rd(1'b1, r);
    chk(r == 8'h01, "R8 status done", r, 1);
    rd(1'b0, r);
    chk(int'(r) == v, "R7 result", r, v);
    chk(refl == 4'(1 << sel), "R3 reference one-hot", refl, 1 << sel);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(refl == 4'b0001, "R1 ref after reset", refl, 1);
    chk(hold == 1'b0, "R1 hold after reset", hold, 0);
    chk(dac == 8'h00, "R1 dac after reset", dac, 0);
    rd(1'b1, r); chk(r == 8'h00, "R1 status after reset", r, 0);
    rd(1'b0, r); chk(r == 8'h00, "R1 data after reset", r, 0);
    // R2 ack gating
    cyc = 1'b1; stb = 1'b0; #1; chk(ack == 1'b0, "R2 ack stb low", ack, 0);
    cyc = 1'b0; stb = 1'b1; #1; chk(ack == 1'b0, "R2 ack cyc low", ack, 0);
    stb = 1'b0;
    @(negedge clk);
    // R5 trial sequences on chosen values
    convert(0, 0, 1'b1);
    convert(255, 1, 1'b1);
    convert(128, 2, 1'b1);
    convert(127, 3, 1'b1);
    convert(165, 1, 1'b1);
    convert(90, 2, 1'b1);
    // R7 exhaustive sweep
    for (int v = 0; v < 256; v++) convert(v, v % 4, 1'b0);
    // now done=1, result=255, ref index 3
    // R11 reference change without start
    drive(1'b1, 1'b1, 1'b0, 8'h01);
    chk(refl == 4'b0010, "R11 ref changed", refl, 2);
    chk(hold == 1'b0, "R11 no start", hold, 0);
    rd(1'b1, r); chk(r == 8'h01, "R11 done kept", r, 1);
    rd(1'b0, r); chk(r == 8'hFF, "R11 result kept", r, 255);
    // R9 ignored writes
    vin = 10;
    drive(1'b1, 1'b1, 1'b1, 8'h07);
    chk(refl == 4'b0010, "R9 addr1 ref", refl, 2);
    chk(hold == 1'b0, "R9 addr1 no start", hold, 0);
    drive(1'b0, 1'b1, 1'b0, 8'h07);
    chk(refl == 4'b0010, "R9 cyc low ref", refl, 2);
    chk(hold == 1'b0, "R9 cyc low no start", hold, 0);
    drive(1'b1, 1'b0, 1'b0, 8'h06);
    chk(refl == 4'b0010, "R9 stb low ref", refl, 2);
    chk(hold == 1'b0, "R9 stb low no start", hold, 0);
    rd(1'b1, r); chk(r == 8'h01, "R9 done kept", r, 1);
    rd(1'b0, r); chk(r == 8'hFF, "R9 result kept", r, 255);
    // R10 restart in mid-search
    vin = 200;
    drive(1'b1, 1'b1, 1'b0, 8'h04);
    repeat (3) @(negedge clk);
    vin = 37;
    drive(1'b1, 1'b1, 1'b0, 8'h05);
    chk(dac == 8'h7F, "R10 restart code", dac, 8'h7F);
    for (int j = 0; j < 8; j++) begin
      rd(1'b1, r);
      chk(r == 8'h00, "R10 no early done", r, 0);
      @(negedge clk);
    end
    rd(1'b1, r); chk(r == 8'h01, "R10 done after restart", r, 1);
    rd(1'b0, r); chk(r == 8'd37, "R10 restart result", r, 37);
    chk(refl == 4'b0010, "R10 ref", refl, 2);
    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule